// File: doc/BRIEF.md
# Slot-Priority Backplane Bus Arbiter

This block decides which source on a shared backplane bus is master. Every source sits in a physical slot. Slot 0 is the most upstream slot, and a higher index means further downstream. Each source raises a request line while it wants the bus. The arbiter answers with a one-hot grant vector, the binary index of the owner and a busy flag. It only decides and holds mastership. The data path and the transfer protocol belong to other blocks.

A master keeps the bus for as long as its request stays high and it does not pulse its release line. When it lets go, the grant is withdrawn for one cycle. On the next edge a complete arbitration runs again over every pending request. The winner is chosen by slot position alone, so an upstream source can take the bus even if the previous master sat downstream. A source that just released the bus may request it again straight away and competes like any other source. Sources feeding one event can therefore win in any order. No event-sequencing signal enters the arbiter, so nothing in event control can stall a grant. The slot count is a parameter.

Top module: `slot_bus_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, the grant vector is all zeros after that edge.
- R2: When no slot holds the bus and at least one request is high at an edge, the grant after that edge goes to the requesting slot with the lowest index, because slot 0 is upstream.
- R3: At most one grant bit is ever high.
- R4: While the master keeps its request high and does not pulse its release bit, its grant stays unchanged, even when upstream slots request.
- R5: When the master's release bit is high, or its request is low, at an edge, all grants are zero after that edge.
- R6: The arbitration that follows a release considers every pending request, so an upstream requester wins over the downstream slot that held the bus before.
- R7: A slot that has just released the bus and requests again competes normally, and it wins when it is the lowest-index requester.
- R8: With no request high, the grant vector stays all zeros.
- R9: A release bit belonging to a slot that is not master, or given while the bus is free, has no effect on the grant.
- R10: The owner output gives the index of the granted slot, and 0 when none is granted. The busy output is high exactly when one grant bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N | Request line of each slot, high while the slot wants the bus |
| rel | input | N | Release indication of each slot; acted on only for the current master |
| grant | output | N | One-hot mastership grant |
| owner | output | IW | Index of the granted slot |
| busy | output | 1 | High while some slot holds the bus |

## Verification
Two functions can land in the same cycle. One is the master giving up the bus, by its release bit or by dropping its request. The other is a competing request from an upstream slot, or a new request from the master itself. The bench provokes this by keeping an upstream request high across the release edge, and by having the departing master hold or reassert its request in that edge. The result is judged over two edges: the grant must first go all-zero, and only then go to the lowest-index requester, which is the former master only when nothing upstream of it is pending.

// File: rtl/slot_arb_pkg.sv
// Shared types for the slot-priority arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package slot_arb_pkg;

    // Bus ownership condition as seen by the grant register.
    typedef enum logic {
        ARB_FREE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/slot_priority_pick.sv
// Fixed-priority selector: the lowest-index (most upstream) requester wins.
// Assumes: req is already qualified. The result is combinational, one level per slot.
module slot_priority_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);

    logic [N-1:0] blocked;

    // Each slot is blocked by any request upstream of it.
    assign blocked[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_block
            assign blocked[g] = blocked[g-1] | req[g-1];
        end
        for (g = 0; g < N; g++) begin : g_pick
            assign pick[g] = req[g] & ~blocked[g];
        end
    endgenerate

    // Flags that at least one request is present.
    assign any = |req;

endmodule

// File: rtl/grant_keeper.sv
// Holds the grant. It loads a fresh pick only while the bus is free and drops to
// zero for one cycle when the master lets go.
// Assumes: pick is one-hot or zero. Synchronous active-low reset.
module grant_keeper
    import slot_arb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] rel,
    input  logic [N-1:0] pick,
    input  logic         any,
    output logic [N-1:0] grant
);

    arb_state_e state;
    logic       master_done;

    // Ownership condition is derived from the grant register itself.
    assign state = (|grant) ? ARB_OWNED : ARB_FREE;

    // The master lets go by pulsing its release bit or by dropping its request.
    assign master_done = |(grant & (rel | ~req));

    // Grant register: arbitrate when free, hold while owned, clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else begin
            case (state)
                ARB_FREE:  grant <= any ? pick : '0;
                ARB_OWNED: if (master_done) grant <= '0;
                default:   grant <= '0;
            endcase
        end
    end

endmodule

// File: rtl/owner_encoder.sv
// Turns a one-hot grant into a binary slot index and a busy flag.
// Assumes: onehot has at most one bit set.
module owner_encoder #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  onehot,
    output logic [IW-1:0] index,
    output logic          busy
);

    // OR together the indices of the set bits; only one bit can be set.
    always_comb begin
        index = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) index = index | IW'(i);
        end
    end

    // Busy while any grant bit is set.
    assign busy = |onehot;

endmodule

// File: rtl/slot_bus_arbiter.sv
// Top level: slot-ordered bus arbiter that runs a full arbitration after every release.
// Assumes: slot 0 is the most upstream slot. Requests are synchronous to clk.
module slot_bus_arbiter #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  rel,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] owner,
    output logic          busy
);

    logic [N-1:0] pick;
    logic         any;

    slot_priority_pick #(.N(N)) u_pick (
        .req  (req),
        .pick (pick),
        .any  (any)
    );

    grant_keeper #(.N(N)) u_keep (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .rel   (rel),
        .pick  (pick),
        .any   (any),
        .grant (grant)
    );

    owner_encoder #(.N(N), .IW(IW)) u_enc (
        .onehot (grant),
        .index  (owner),
        .busy   (busy)
    );

endmodule

// Property checker for the arbiter, attached by bind below.
// Assumes: it observes the same clock and synchronous reset as the arbiter.
module slot_bus_arbiter_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic [N-1:0] rel,
    input logic [N-1:0] grant
);

    // R1: reset clears every grant
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (grant == '0));

    // R3: never more than one master
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: a free bus goes to the lowest-index requester
    a_r2_upstream_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req != '0) |=> (grant == ($past(req) & (~$past(req) + 1'b1))));

    // R4: a master that keeps requesting and does not release keeps the bus
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & req) == grant && (grant & rel) == '0) |=> $stable(grant));

    // R5: release or request drop frees the bus for one cycle
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && ((grant & rel) != '0 || (grant & req) == '0)) |=> (grant == '0));

    // R8: no request keeps the bus idle
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req == '0) |=> (grant == '0));

endmodule

bind slot_bus_arbiter slot_bus_arbiter_chk #(.N(N)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .rel   (rel),
    .grant (grant)
);

// File: tb/test_slot_bus_arbiter.sv
// Self-checking bench: a vector walk, then directed reset cases.
module test_slot_bus_arbiter;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  rel = '0;
    logic [N-1:0]  grant;
    logic [IW-1:0] owner;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    slot_bus_arbiter #(.N(N)) i_slot_bus_arbiter (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .rel   (rel),
        .grant (grant),
        .owner (owner),
        .busy  (busy)
    );

    // Vector fields: {req, rel, expected grant after one edge, requirement number}
    localparam logic [55:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 16'h0000, 8'd8},  // R8 idle
        {16'h0100, 16'h0000, 16'h0100, 8'd2},  // R2 slot 8 alone
        {16'h0101, 16'h0000, 16'h0100, 8'd4},  // R4 hold against upstream slot 0
        {16'h0101, 16'h0001, 16'h0100, 8'd9},  // R9 non-master release ignored
        {16'h0101, 16'h0100, 16'h0000, 8'd5},  // R5 master release
        {16'h0101, 16'h0000, 16'h0001, 8'd6},  // R6 upstream wins fresh arbitration
        {16'h0100, 16'h0000, 16'h0000, 8'd5},  // R5 request drop
        {16'h0100, 16'h0000, 16'h0100, 8'd2},  // R2
        {16'h0100, 16'h0100, 16'h0000, 8'd5},  // R5 release while still requesting
        {16'h8100, 16'h0000, 16'h0100, 8'd7},  // R7 former master competes and wins
        {16'h8000, 16'h0000, 16'h0000, 8'd5},  // R5
        {16'h8000, 16'h0000, 16'h8000, 8'd2},  // R2 most downstream slot
        {16'h0000, 16'h0000, 16'h0000, 8'd5},  // R5
        {16'h0004, 16'h0004, 16'h0004, 8'd9},  // R9 release on free bus ignored
        {16'h0000, 16'h0000, 16'h0000, 8'd5},  // R5
        {16'h0000, 16'h0000, 16'h0000, 8'd8}   // R8
    };

    function automatic logic [IW-1:0] exp_owner(input logic [N-1:0] g);
        exp_owner = '0;
        for (int i = 0; i < N; i++) if (g[i]) exp_owner = IW'(i);
    endfunction

    task automatic check_out(input logic [N-1:0] eg, input int rq);
        checks++;
        if (grant !== eg) begin
            errors++;
            $display("FAIL R%0d grant actual %h expected %h", rq, grant, eg);
        end
        checks++;   // R10 owner and busy
        if (owner !== exp_owner(eg) || busy !== (eg != '0)) begin
            errors++;
            $display("FAIL R10 owner/busy actual %0d/%b expected %0d/%b",
                     owner, busy, exp_owner(eg), (eg != '0));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check_out('0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            req = VEC[v][55:40];
            rel = VEC[v][39:24];
            @(negedge clk);
            check_out(VEC[v][23:8], int'(VEC[v][7:0]));
        end
        // R1: reset while a slot holds the bus
        req = 16'h0010; rel = '0;
        @(negedge clk);
        check_out(16'h0010, 2);
        rst_n = 1'b0;
        @(negedge clk);
        check_out('0, 1);
        // R1: reset overrides requests on every cycle it is held
        @(negedge clk);
        check_out('0, 1);
        rst_n = 1'b1;
        // R6 after reset: upstream slot 3 beats slot 4
        req = 16'h0018;
        @(negedge clk);
        check_out(16'h0008, 6);
        // R4: the master keeps the bus while slot 0 also requests
        req = 16'h0019;
        @(negedge clk);
        check_out(16'h0008, 4);
        req = '0;
        @(negedge clk);
        check_out('0, 5);
        finish_run();
    end

endmodule